// File: doc/BRIEF.md
# Byte Lane Compare and Zap Unit

This unit works on 64-bit operands split into eight byte lanes and offers three lane-parallel operations. The compare operation checks, lane by lane, whether the byte of operand A is greater than or equal to the byte of operand B, with both bytes read as unsigned. It returns the eight answers as a bit mask in the low byte of the result. The clear operation zeroes every lane of A whose bit is set in a lane mask taken from operand B. The keep operation inverts that mask, so it zeroes every lane whose bit is clear and passes the rest of A through unchanged.

Operand B is either a full 64-bit register value or an 8-bit literal that is zero-extended to 64 bits. A single output register holds the result. Requests and results move over valid/ready handshakes. A request is taken on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle. A result is held unchanged while `out_valid` is high and `out_ready` is low. A new request is therefore refused only while a result is waiting and the consumer is stalling.

Top module: `lane_cmp_zap`

## Requirements
- R1: With op = 2'b00 (compare), result bit k is 1 exactly when byte lane k of A (bits 8k+7..8k, lane 0 = bits 7..0) is unsigned greater than or equal to byte lane k of the effective B.
- R2: With op = 2'b00, result bits 63..8 are zero.
- R3: With op = 2'b01 (clear), byte lane k of the result is zero when bit k of the effective B is 1, and equals byte lane k of A otherwise.
- R4: With op = 2'b10 (keep), byte lane k of the result equals byte lane k of A when bit k of the effective B is 1, and is zero otherwise.
- R5: For op = 2'b01 and op = 2'b10, bits 63..8 of the effective B have no effect on the result.
- R6: When use_lit is 1, the effective B is lit zero-extended to 64 bits and b_in has no effect. When use_lit is 0, the effective B is b_in.
- R7: With op = 2'b11 (reserved), the result is all zero.
- R8: in_ready equals (not out_valid) or out_ready. An accepted request makes out_valid high in the next cycle with its result, and results leave in acceptance order.
- R9: While out_valid is high and out_ready is low, res and out_valid hold their values into the next cycle.
- R10: After reset, out_valid is 0, res is 0 and in_ready is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request this cycle |
| op | input | 2 | 00 compare, 01 clear, 10 keep, 11 reserved (zero result) |
| a_in | input | 64 | Operand A |
| b_in | input | 64 | Register form of operand B |
| lit | input | 8 | Literal form of operand B |
| use_lit | input | 1 | 1 selects the zero-extended literal as B |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| res | output | 64 | Result |

## Verification
The bench uses the default parameters: eight lanes of eight bits and an 8-bit literal. With these, a literal can express every one of the 256 lane masks, and a random 64-bit B with random upper bits exercises the rule that only the low byte selects lanes. Random operands are often set equal lane by lane, so the equality boundary of the compare is hit in most requests. Lanes that straddle 0x7F and 0x80 expose any signed comparison. Random stalls on out_ready check ordering and holding while the output register is full.

// File: rtl/lcz_pkg.sv
package lcz_pkg;

  typedef enum logic [1:0] {
    LCZ_OP_CMPGE = 2'b00,
    LCZ_OP_CLEAR = 2'b01,
    LCZ_OP_KEEP  = 2'b10,
    LCZ_OP_NONE  = 2'b11
  } lcz_op_e;

endpackage

// File: rtl/lcz_operand_sel.sv
// Chooses the effective B operand: register value or zero-extended literal.
module lcz_operand_sel #(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8
) (
  input  logic [DATA_W-1:0] b_reg,
  input  logic [LIT_W-1:0]  lit,
  input  logic              use_lit,
  output logic [DATA_W-1:0] b_eff
);
  localparam int PAD_W = DATA_W - LIT_W;

  logic [DATA_W-1:0] lit_ext;

  generate
    if (PAD_W > 0) begin : g_pad
      assign lit_ext = {{PAD_W{1'b0}}, lit};
    end else begin : g_nopad
      assign lit_ext = lit[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    b_eff = use_lit ? lit_ext : b_reg;
  end
endmodule

// File: rtl/lcz_lane_cmp.sv
// Unsigned greater-or-equal per lane; one mask bit per lane.
module lcz_lane_cmp #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES*LANE_W-1:0] b,
  output logic [LANES-1:0]        ge_mask
);
  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [LANE_W-1:0] a_lane;
      logic [LANE_W-1:0] b_lane;
      logic [LANE_W:0]   diff;
      assign a_lane = a[k*LANE_W +: LANE_W];
      assign b_lane = b[k*LANE_W +: LANE_W];
      // a - b without borrow out means a >= b
      assign diff = {1'b0, a_lane} - {1'b0, b_lane};
      assign ge_mask[k] = ~diff[LANE_W];
    end
  endgenerate
endmodule

// File: rtl/lcz_lane_zap.sv
// Clears or keeps whole lanes of A under a bit-per-lane select mask.
module lcz_lane_zap #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] a,
  input  logic [LANES-1:0]        sel,
  input  logic                    keep_sel,
  output logic [LANES*LANE_W-1:0] y
);
  logic [LANES-1:0] pass;

  generate
    for (genvar k = 0; k < LANES; k++) begin : g_lane
      // clear mode passes unselected lanes, keep mode passes selected ones
      assign pass[k] = ~(sel[k] ^ keep_sel);
      assign y[k*LANE_W +: LANE_W] = pass[k] ? a[k*LANE_W +: LANE_W]
                                             : {LANE_W{1'b0}};
    end
  endgenerate
endmodule

// File: rtl/lcz_out_stage.sv
// Single result register with valid/ready on both sides.
module lcz_out_stage #(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_valid,
  output logic              up_ready,
  input  logic [DATA_W-1:0] up_data,
  output logic              dn_valid,
  input  logic              dn_ready,
  output logic [DATA_W-1:0] dn_data
);
  logic              full_q;
  logic [DATA_W-1:0] data_q;

  assign up_ready = ~full_q | dn_ready;
  assign dn_valid = full_q;
  assign dn_data  = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else if (up_ready) begin
      full_q <= up_valid;
      if (up_valid) begin
        data_q <= up_data;
      end
    end
  end
endmodule

// File: rtl/lane_cmp_zap.sv
module lane_cmp_zap #(
  parameter int LANES  = 8,
  parameter int LANE_W = 8,
  parameter int LIT_W  = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [1:0]              op,
  input  logic [LANES*LANE_W-1:0] a_in,
  input  logic [LANES*LANE_W-1:0] b_in,
  input  logic [LIT_W-1:0]        lit,
  input  logic                    use_lit,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic [LANES*LANE_W-1:0] res
);
  import lcz_pkg::*;

  localparam int DATA_W  = LANES * LANE_W;
  localparam int UPPER_W = DATA_W - LANES;

  lcz_op_e           op_e;
  logic [DATA_W-1:0] b_eff;
  logic [LANES-1:0]  ge_mask;
  logic [DATA_W-1:0] zap_y;
  logic [DATA_W-1:0] cmp_y;
  logic [DATA_W-1:0] next_res;

  assign op_e = lcz_op_e'(op);

  lcz_operand_sel #(.DATA_W(DATA_W), .LIT_W(LIT_W)) u_opsel (
    .b_reg   (b_in),
    .lit     (lit),
    .use_lit (use_lit),
    .b_eff   (b_eff)
  );

  lcz_lane_cmp #(.LANES(LANES), .LANE_W(LANE_W)) u_cmp (
    .a       (a_in),
    .b       (b_eff),
    .ge_mask (ge_mask)
  );

  lcz_lane_zap #(.LANES(LANES), .LANE_W(LANE_W)) u_zap (
    .a        (a_in),
    .sel      (b_eff[LANES-1:0]),
    .keep_sel (op_e == LCZ_OP_KEEP),
    .y        (zap_y)
  );

  generate
    if (UPPER_W > 0) begin : g_cmp_ext
      assign cmp_y = {{UPPER_W{1'b0}}, ge_mask};
    end else begin : g_cmp_flat
      assign cmp_y = ge_mask[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (op_e)
      LCZ_OP_CMPGE: next_res = cmp_y;
      LCZ_OP_CLEAR,
      LCZ_OP_KEEP:  next_res = zap_y;
      default:      next_res = '0;
    endcase
  end

  lcz_out_stage #(.DATA_W(DATA_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .up_valid (in_valid),
    .up_ready (in_ready),
    .up_data  (next_res),
    .dn_valid (out_valid),
    .dn_ready (out_ready),
    .dn_data  (res)
  );
endmodule

// File: rtl/lcz_checker.sv
module lcz_checker #(
  parameter int DATA_W = 64,
  parameter int LIT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [1:0]        op,
  input logic [LIT_W-1:0]  lit,
  input logic              use_lit,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] res
);
  logic take;
  assign take = in_valid && in_ready;

  // R8
  accept_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  stall_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R8
  drain_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(res)));

  // R2
  cmp_upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b00) |=> (res[DATA_W-1:8] == '0));

  // R7
  none_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b11) |=> (res == '0));

  // R4
  keep_empty_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b10 && use_lit && lit == '0) |=> (res == '0));
endmodule

bind lane_cmp_zap lcz_checker #(.DATA_W(LANES*LANE_W), .LIT_W(LIT_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .op        (op),
  .lit       (lit),
  .use_lit   (use_lit),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .res       (res)
);

// File: tb/tb_lane_cmp_zap.sv
module tb_lane_cmp_zap;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic        in_ready;
  logic [1:0]  op;
  logic [63:0] a_in;
  logic [63:0] b_in;
  logic [7:0]  lit;
  logic        use_lit;
  logic        out_valid;
  logic        out_ready;
  logic [63:0] res;

  int checks = 0;
  int fails  = 0;
  bit rdy_random = 1'b1;
  bit stall_prev = 1'b0;
  logic [63:0] held;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  lane_cmp_zap dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .a_in(a_in), .b_in(b_in), .lit(lit), .use_lit(use_lit),
    .out_valid(out_valid), .out_ready(out_ready), .res(res)
  );

  function automatic logic [63:0] model(input logic [63:0] a, input logic [63:0] b,
                                        input logic [7:0] l, input logic ul,
                                        input logic [1:0] o);
    logic [63:0] bb;
    logic [63:0] r;
    bb = ul ? {56'd0, l} : b;
    r = '0;
    for (int k = 0; k < 8; k++) begin
      case (o)
        2'b00: r[k] = (a[8*k +: 8] >= bb[8*k +: 8]);
        2'b01: r[8*k +: 8] = bb[k] ? 8'h00 : a[8*k +: 8];
        2'b10: r[8*k +: 8] = bb[k] ? a[8*k +: 8] : 8'h00;
        default: r = '0;
      endcase
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle of the handshake loop, entered and left at a falling edge
  task automatic tick(output bit accepted);
    out_ready = rdy_random ? (($urandom % 4) != 0) : 1'b1;
    #1;
    check(in_ready == (!out_valid || out_ready), "R8 ready rule",
          {63'd0, in_ready}, {63'd0, (!out_valid || out_ready)});
    if (stall_prev) begin
      check(out_valid && res == held, "R9 hold", res, held);
    end
    if (out_valid && out_ready) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R8 unexpected result", res, 64'd0);
      end else begin
        check(res == exp_q[0], tag_q[0], res, exp_q[0]);
        void'(exp_q.pop_front());
        void'(tag_q.pop_front());
      end
    end
    stall_prev = out_valid && !out_ready;
    held = res;
    accepted = in_valid && in_ready;
    if (accepted) begin
      exp_q.push_back(model(a_in, b_in, lit, use_lit, op));
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send(input logic [63:0] a, input logic [63:0] b,
                      input logic [7:0] l, input logic ul,
                      input logic [1:0] o, input string tag);
    bit acc;
    a_in = a; b_in = b; lit = l; use_lit = ul; op = o;
    in_valid = 1'b1;
    acc = 1'b0;
    while (!acc) begin
      tick(acc);
    end
    tag_q.push_back(tag);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b1, "R8 latency", {63'd0, out_valid}, 64'd1);
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R8 actual=hang expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bit acc;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    op = 2'b00; a_in = '0; b_in = '0; lit = '0; use_lit = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10
    check(out_valid == 1'b0, "R10 valid", {63'd0, out_valid}, 64'd0);
    check(res == 64'd0, "R10 res", res, 64'd0);
    check(in_ready == 1'b1, "R10 ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);

    // directed corner cases
    send(64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 8'h00, 1'b0, 2'b00, "R1 R2 equal lanes");
    send(64'h0000_0000_0000_0000, 64'h0101_0101_0101_0101, 8'h00, 1'b0, 2'b00, "R1 all below");
    send(64'h8080_8080_8080_8080, 64'h7F7F_7F7F_7F7F_7F7F, 8'h00, 1'b0, 2'b00, "R1 unsigned 80 vs 7F");
    send(64'h00FF_00FF_00FF_00FF, 64'hFF00_FF00_FF00_FF00, 8'h00, 1'b0, 2'b00, "R1 alternating lanes");
    send(64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 8'h00, 1'b0, 2'b00, "R2 all ones vs zero");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'h0000_0000_0000_00FF, 8'h00, 1'b0, 2'b01, "R3 clear all");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'd0, 8'h00, 1'b0, 2'b01, "R3 clear none");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FF00, 8'h00, 1'b0, 2'b01, "R5 clear upper B ignored");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FF5A, 8'h00, 1'b0, 2'b10, "R4 R5 keep 5A");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'd0, 8'hFF, 1'b1, 2'b10, "R4 keep all by literal");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'hFFFF_FFFF_FFFF_FFFF, 8'h81, 1'b1, 2'b01, "R6 literal clear 81");
    send(64'h1111_1111_1111_1111, 64'hFFFF_FFFF_FFFF_FFFF, 8'h10, 1'b1, 2'b00, "R6 literal compare");
    send(64'hDEAD_BEEF_CAFE_F00D, 64'h1234, 8'h77, 1'b0, 2'b11, "R7 reserved op");

    // random mix with random consumer stalls
    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      logic [63:0] b;
      a = rnd64();
      b = rnd64();
      for (int k = 0; k < 8; k++) begin
        if (($urandom % 3) == 0) b[8*k +: 8] = a[8*k +: 8];
      end
      send(a, b, 8'($urandom), 1'($urandom), 2'($urandom),
           "R1 R3 R4 R5 R6 R7 random");
      if (($urandom % 5) == 0) tick(acc);
    end

    // drain
    rdy_random = 1'b0;
    for (int n = 0; n < 8 && exp_q.size() != 0; n++) begin
      tick(acc);
    end
    tick(acc);
    #1;
    check(exp_q.size() == 0, "R8 all results delivered", 64'(exp_q.size()), 64'd0);
    check(out_valid == 1'b0, "R8 empty after drain", {63'd0, out_valid}, 64'd0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule